// File: doc/BRIEF.md
# Register Rename Stage with Rollback Log

This block renames registers for a small out-of-order core. Decode hands it groups of up to `REN_W` instructions. Each instruction carries a sequence number, two architectural source registers and one architectural destination register. The block translates the sources through a map table. It gives every destination a fresh physical register taken from a circular free list. It then sends the renamed group toward issue one cycle later.

Every instruction that is renamed leaves a record in an ordered rollback log. The record holds:
- the sequence number,
- the architectural destination,
- the new physical register,
- the physical register it displaced.

Retirement trims the log from its oldest end and recycles the displaced registers. A squash from the execute stage unwinds the log from its youngest end. During the unwind the block puts the map back as it was and recycles the registers that had been handed out.

Incoming groups wait in a small group queue (the skid queue). A group that is only partly renamed stays at the front of that queue. Renaming picks it up again at the first instruction not yet done, because the reorder-buffer credits, issue-queue credits and free registers are all checked one instruction at a time.

Top module: `rnm_rename`

## Requirements
- R1: A group is accepted into the skid queue when any bit of `dec_vld` is set while `dec_ready` is high. Valid slots are contiguous from slot 0. `dec_ready` is low while the skid queue is full or a squash unwind is in progress. Groups are renamed in arrival order.
- R2: At most `REN_W` instructions are renamed per cycle, in program order. Their results appear on the issue outputs at the clock edge that ends the renaming cycle, packed from issue slot 0 upward, so that `iss_vld` is contiguous from bit 0.
- R3: Renaming stops at the first instruction for which one of these holds: the number already renamed this cycle is at least `rob_free`; it is at least `iq_free`; the instruction needs a destination and no free register is left this cycle; or the log is full. Nothing after that instruction is renamed in that cycle, and `stall_o` is high in that cycle.
- R4: A partly renamed group stays at the front of the skid queue, and renaming resumes at its first unrenamed instruction. The group leaves the queue only when all of its valid slots are renamed.
- R5: Sources are translated before the destination mapping is updated. A source that names the destination of an earlier instruction in the same group receives that instruction's new physical register.
- R6: Architectural register 0 always reads as physical register 0. A destination of 0 means there is no destination: `iss_wr` is 0, `iss_pdst` is 0, no free register is consumed, and a placeholder log entry is still written.
- R7: After reset, architectural register i maps to physical register i. The free list holds `ARCH_REGS` to `PHYS_REGS-1` in increasing order. Free registers are handed out first-in first-out, and returned registers join the tail of the list.
- R8: A commit with sequence number C removes log entries with sequence number at or below C, oldest first, one per cycle. Each removed entry that is not a placeholder returns its displaced register to the free list.
- R9: A squash with sequence number S has these effects:
  - It suppresses renaming in its own cycle and empties the skid queue, including any group accepted in that cycle.
  - From the next cycle it removes one log entry per cycle, youngest first, while the youngest entry's sequence number exceeds S.
  - For each removed entry that is not a placeholder, it restores the map entry to the displaced register and returns the new register to the free list.
- R10: After reset, `iss_vld` is 0, `dec_ready` is 1 and `stall_o` is 0. `iss_vld` is 0 after any cycle in which nothing was renamed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_vld | input | REN_W | Per-slot valid of the incoming group |
| dec_seq | input | REN_W*SEQ_W | Per-slot sequence numbers |
| dec_src1 | input | REN_W*AREG_W | Per-slot first architectural source |
| dec_src2 | input | REN_W*AREG_W | Per-slot second architectural source |
| dec_dst | input | REN_W*AREG_W | Per-slot architectural destination (0 = none) |
| dec_ready | output | 1 | Group acceptance allowed |
| rob_free | input | CRED_W | Free reorder-buffer entries this cycle |
| iq_free | input | CRED_W | Free issue-queue entries this cycle |
| cm_valid | input | 1 | Commit report valid |
| cm_seq | input | SEQ_W | Youngest retired sequence number |
| sq_valid | input | 1 | Squash request from execute |
| sq_seq | input | SEQ_W | Youngest surviving sequence number |
| iss_vld | output | REN_W | Per-slot valid toward issue |
| iss_seq | output | REN_W*SEQ_W | Per-slot sequence numbers |
| iss_psrc1 | output | REN_W*PREG_W | Per-slot first physical source |
| iss_psrc2 | output | REN_W*PREG_W | Per-slot second physical source |
| iss_pdst | output | REN_W*PREG_W | Per-slot physical destination |
| iss_wr | output | REN_W | Per-slot destination present |
| stall_o | output | 1 | Rename blocked by a resource this cycle |

## Verification
The assertions rely on a few rules for the inputs:
- Sequence numbers rise and never wrap.
- A commit number never exceeds the number of a pending squash.
- Decode offers a group only while `dec_ready` is high, with its valid slots packed from slot 0.

Under those rules the log head and the log tail never refer to the same entry in one cycle. The stimulus follows them: it uses strictly increasing sequence numbers, commits only work older than any squash, and drives a group for exactly one cycle, and only when the queue has room.

// File: rtl/rnm_pkg.sv
package rnm_pkg;

    localparam int ARCH_REGS  = 8;
    localparam int PHYS_REGS  = 16;
    localparam int REN_W      = 2;
    localparam int SEQ_W      = 8;
    localparam int HIST_DEPTH = 16;
    localparam int SKID_DEPTH = 4;
    localparam int CRED_W     = 4;

    localparam int AREG_W  = $clog2(ARCH_REGS);
    localparam int PREG_W  = $clog2(PHYS_REGS);
    localparam int RIDX_W  = $clog2(REN_W + 1);
    localparam int FCNT_W  = $clog2(PHYS_REGS + 1);
    localparam int HCNT_W  = $clog2(HIST_DEPTH + 1);
    localparam int SPARE_REGS = PHYS_REGS - ARCH_REGS;

    typedef logic [AREG_W-1:0] areg_t;
    typedef logic [PREG_W-1:0] preg_t;
    typedef logic [SEQ_W-1:0]  seq_t;

    typedef struct packed {
        logic  vld;
        seq_t  seq;
        areg_t src1;
        areg_t src2;
        areg_t dst;
    } dslot_t;

    typedef dslot_t [REN_W-1:0] dgroup_t;

    typedef struct packed {
        seq_t  seq;
        logic  ph;
        areg_t arch;
        preg_t newp;
        preg_t prevp;
    } hist_t;

    typedef struct packed {
        logic  vld;
        seq_t  seq;
        preg_t ps1;
        preg_t ps2;
        preg_t pd;
        logic  wr;
    } rslot_t;

    function automatic logic seq_after(input seq_t a, input seq_t b);
        return a > b;
    endfunction

endpackage

// File: rtl/rnm_freelist.sv
module rnm_freelist
    import rnm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RIDX_W-1:0] pop_n,
    input  logic [1:0]        push_v,
    input  preg_t             push_d0,
    input  preg_t             push_d1,
    output preg_t             heads [REN_W],
    output logic [FCNT_W-1:0] count
);
    localparam int PTR_W = $clog2(PHYS_REGS);

    preg_t             mem [PHYS_REGS];
    logic [PTR_W-1:0]  rd_q, wr_q;
    logic [FCNT_W-1:0] cnt_q;
    logic [PTR_W-1:0]  wr_second;
    logic [1:0]        n_push;

    assign wr_second = wr_q + PTR_W'(push_v[0]);
    assign n_push    = 2'(push_v[0]) + 2'(push_v[1]);
    assign count     = cnt_q;

    for (genvar k = 0; k < REN_W; k++) begin : g_head
        assign heads[k] = mem[rd_q + PTR_W'(k)];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= PTR_W'(SPARE_REGS);
            cnt_q <= FCNT_W'(SPARE_REGS);
            for (int i = 0; i < PHYS_REGS; i++)
                mem[i] <= (i < SPARE_REGS) ? PREG_W'(ARCH_REGS + i) : '0;
        end else begin
            rd_q  <= rd_q + PTR_W'(pop_n);
            wr_q  <= wr_q + PTR_W'(n_push);
            cnt_q <= cnt_q + FCNT_W'(n_push) - FCNT_W'(pop_n);
            if (push_v[0]) mem[wr_q] <= push_d0;
            if (push_v[1]) mem[wr_second] <= push_d1;
        end
    end
endmodule

// File: rtl/rnm_hist.sv
module rnm_hist
    import rnm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RIDX_W-1:0] push_n,
    input  hist_t             push_e [REN_W],
    input  logic              pop_head,
    input  logic              pop_tail,
    output seq_t              head_seq,
    output logic              head_ph,
    output preg_t             head_prevp,
    output hist_t             tail_e,
    output logic [HCNT_W-1:0] count
);
    localparam int PTR_W = $clog2(HIST_DEPTH);

    hist_t             mem [HIST_DEPTH];
    logic [PTR_W-1:0]  hd_q, tl_q;
    logic [HCNT_W-1:0] cnt_q;
    hist_t             head_e;

    assign head_e     = mem[hd_q];
    assign head_seq   = head_e.seq;
    assign head_ph    = head_e.ph;
    assign head_prevp = head_e.prevp;
    assign tail_e     = mem[tl_q - PTR_W'(1)];
    assign count      = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hd_q  <= '0;
            tl_q  <= '0;
            cnt_q <= '0;
        end else begin
            hd_q  <= hd_q + PTR_W'(pop_head);
            tl_q  <= tl_q + PTR_W'(push_n) - PTR_W'(pop_tail);
            cnt_q <= cnt_q + HCNT_W'(push_n) - HCNT_W'(pop_head) - HCNT_W'(pop_tail);
            for (int i = 0; i < REN_W; i++)
                if (i < int'(push_n)) mem[tl_q + PTR_W'(i)] <= push_e[i];
        end
    end
endmodule

// File: rtl/rnm_skid.sv
module rnm_skid
    import rnm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  dgroup_t push_g,
    input  logic    pop,
    input  logic    flush,
    output dgroup_t head_g,
    output logic    empty,
    output logic    full
);
    localparam int PTR_W = $clog2(SKID_DEPTH);
    localparam int CNT_W = $clog2(SKID_DEPTH + 1);

    dgroup_t          mem [SKID_DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;

    assign head_g = mem[rd_q];
    assign empty  = (cnt_q == '0);
    assign full   = (cnt_q == CNT_W'(SKID_DEPTH));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem[wr_q] <= push_g;
                wr_q      <= wr_q + PTR_W'(1);
            end
            if (pop) rd_q <= rd_q + PTR_W'(1);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/rnm_rename.sv
module rnm_rename
    import rnm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [REN_W-1:0]         dec_vld,
    input  logic [REN_W*SEQ_W-1:0]   dec_seq,
    input  logic [REN_W*AREG_W-1:0]  dec_src1,
    input  logic [REN_W*AREG_W-1:0]  dec_src2,
    input  logic [REN_W*AREG_W-1:0]  dec_dst,
    output logic                     dec_ready,
    input  logic [CRED_W-1:0]        rob_free,
    input  logic [CRED_W-1:0]        iq_free,
    input  logic                     cm_valid,
    input  logic [SEQ_W-1:0]         cm_seq,
    input  logic                     sq_valid,
    input  logic [SEQ_W-1:0]         sq_seq,
    output logic [REN_W-1:0]         iss_vld,
    output logic [REN_W*SEQ_W-1:0]   iss_seq,
    output logic [REN_W*PREG_W-1:0]  iss_psrc1,
    output logic [REN_W*PREG_W-1:0]  iss_psrc2,
    output logic [REN_W*PREG_W-1:0]  iss_pdst,
    output logic [REN_W-1:0]         iss_wr,
    output logic                     stall_o
);
    // architectural map and control state
    preg_t             map_q [ARCH_REGS];
    logic [RIDX_W-1:0] resume_q;
    logic              walk_q;
    seq_t              sq_tgt_q;
    logic              cm_pend_q;
    seq_t              cm_tgt_q;
    rslot_t            iss_q [REN_W];

    // submodule links
    dgroup_t           in_grp, hg;
    logic              sk_empty, sk_full, sk_push, sk_pop;
    preg_t             fl_heads [REN_W];
    logic [FCNT_W-1:0] fl_cnt;
    logic [1:0]        fl_push_v;
    seq_t              h_head_seq;
    logic              h_head_ph;
    preg_t             h_head_prevp;
    hist_t             h_tail;
    logic [HCNT_W-1:0] hcnt;

    // rename datapath
    preg_t             tmap [ARCH_REGS];
    rslot_t            od [REN_W];
    hist_t             pe [REN_W];
    logic              all_done;
    logic [RIDX_W-1:0] ren_cnt, dst_cnt;
    logic              active, hvalid;
    logic              head_pop, walk_pop;
    seq_t              cm_eff;
    logic              cm_eff_v;

    for (genvar k = 0; k < REN_W; k++) begin : g_in
        assign in_grp[k].vld  = dec_vld[k];
        assign in_grp[k].seq  = dec_seq[k*SEQ_W +: SEQ_W];
        assign in_grp[k].src1 = dec_src1[k*AREG_W +: AREG_W];
        assign in_grp[k].src2 = dec_src2[k*AREG_W +: AREG_W];
        assign in_grp[k].dst  = dec_dst[k*AREG_W +: AREG_W];
    end

    assign dec_ready = !sk_full && !walk_q;
    assign sk_push   = (|dec_vld) && dec_ready;
    assign hvalid    = !sk_empty;
    assign active    = !sq_valid && !walk_q;

    rnm_skid u_skid (
        .clk(clk), .rst(rst), .push(sk_push), .push_g(in_grp), .pop(sk_pop),
        .flush(sq_valid), .head_g(hg), .empty(sk_empty), .full(sk_full)
    );

    // rename one group, instruction by instruction, stopping at the first blocked one
    always_comb begin
        int n;
        int nd;
        logic blk;
        tmap     = map_q;
        n        = 0;
        nd       = 0;
        blk      = 1'b0;
        all_done = 1'b1;
        for (int k = 0; k < REN_W; k++) begin
            od[k] = '0;
            pe[k] = '0;
        end
        for (int k = 0; k < REN_W; k++) begin
            dslot_t s;
            logic   needd;
            preg_t  newp;
            s     = hg[k];
            needd = (s.dst != '0);
            newp  = '0;
            if (hvalid && s.vld && (k >= int'(resume_q))) begin
                if (!blk && active && (int'(rob_free) > n) && (int'(iq_free) > n) &&
                    (int'(hcnt) + n < HIST_DEPTH) && (!needd || int'(fl_cnt) > nd)) begin
                    if (needd) newp = fl_heads[nd];
                    od[n].vld = 1'b1;
                    od[n].seq = s.seq;
                    od[n].ps1 = tmap[s.src1];
                    od[n].ps2 = tmap[s.src2];
                    od[n].pd  = newp;
                    od[n].wr  = needd;
                    pe[n].seq   = s.seq;
                    pe[n].ph    = !needd;
                    pe[n].arch  = needd ? s.dst : '0;
                    pe[n].newp  = newp;
                    pe[n].prevp = needd ? tmap[s.dst] : '0;
                    if (needd) begin
                        tmap[s.dst] = newp;
                        nd = nd + 1;
                    end
                    n = n + 1;
                end else begin
                    blk      = 1'b1;
                    all_done = 1'b0;
                end
            end
        end
        ren_cnt = RIDX_W'(n);
        dst_cnt = RIDX_W'(nd);
    end

    assign sk_pop  = hvalid && active && all_done;
    assign stall_o = hvalid && active && !all_done;

    // retirement and squash unwind
    assign cm_eff_v = cm_valid || cm_pend_q;
    assign cm_eff   = cm_valid ? cm_seq : cm_tgt_q;
    assign head_pop = cm_eff_v && (hcnt != '0) && !seq_after(h_head_seq, cm_eff);
    assign walk_pop = walk_q && (hcnt != '0) && seq_after(h_tail.seq, sq_tgt_q);

    assign fl_push_v[0] = head_pop && !h_head_ph;
    assign fl_push_v[1] = walk_pop && !h_tail.ph;

    rnm_freelist u_fl (
        .clk(clk), .rst(rst), .pop_n(dst_cnt), .push_v(fl_push_v),
        .push_d0(h_head_prevp), .push_d1(h_tail.newp), .heads(fl_heads), .count(fl_cnt)
    );

    rnm_hist u_hist (
        .clk(clk), .rst(rst), .push_n(ren_cnt), .push_e(pe), .pop_head(head_pop),
        .pop_tail(walk_pop), .head_seq(h_head_seq), .head_ph(h_head_ph),
        .head_prevp(h_head_prevp), .tail_e(h_tail), .count(hcnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PREG_W'(i);
            resume_q  <= '0;
            walk_q    <= 1'b0;
            sq_tgt_q  <= '0;
            cm_pend_q <= 1'b0;
            cm_tgt_q  <= '0;
            for (int k = 0; k < REN_W; k++) iss_q[k] <= '0;
        end else begin
            cm_pend_q <= cm_eff_v;
            cm_tgt_q  <= cm_eff;
            for (int k = 0; k < REN_W; k++) iss_q[k] <= od[k];
            if (active) begin
                map_q <= tmap;
            end else if (walk_pop && !h_tail.ph) begin
                map_q[h_tail.arch] <= h_tail.prevp;
            end
            if (sq_valid) begin
                walk_q   <= 1'b1;
                sq_tgt_q <= (walk_q && seq_after(sq_seq, sq_tgt_q)) ? sq_tgt_q : sq_seq;
                resume_q <= '0;
            end else begin
                if (walk_q && !walk_pop) walk_q <= 1'b0;
                if (sk_pop)
                    resume_q <= '0;
                else if (hvalid && active)
                    resume_q <= resume_q + ren_cnt;
            end
        end
    end

    for (genvar k = 0; k < REN_W; k++) begin : g_out
        assign iss_vld[k]                   = iss_q[k].vld;
        assign iss_seq[k*SEQ_W +: SEQ_W]    = iss_q[k].seq;
        assign iss_psrc1[k*PREG_W +: PREG_W] = iss_q[k].ps1;
        assign iss_psrc2[k*PREG_W +: PREG_W] = iss_q[k].ps2;
        assign iss_pdst[k*PREG_W +: PREG_W]  = iss_q[k].pd;
        assign iss_wr[k]                    = iss_q[k].wr;
    end
endmodule

// File: rtl/rnm_rename_chk.sv
module rnm_rename_chk
    import rnm_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    dec_ready,
    input logic [CRED_W-1:0]       rob_free,
    input logic [CRED_W-1:0]       iq_free,
    input logic                    sq_valid,
    input logic [REN_W-1:0]        iss_vld,
    input logic [REN_W*PREG_W-1:0] iss_pdst,
    input logic [REN_W-1:0]        iss_wr,
    input logic                    stall_o,
    input logic                    walk_q,
    input logic [FCNT_W-1:0]       fl_cnt,
    input logic [HCNT_W-1:0]       hcnt
);
    assert_unwind_blocks_decode_R9: assert property (@(posedge clk) disable iff (rst)
        walk_q |-> !dec_ready);

    assert_quiet_after_squash_R10: assert property (@(posedge clk) disable iff (rst)
        sq_valid |=> (iss_vld == '0));

    assert_rob_credit_R3: assert property (@(posedge clk) disable iff (rst)
        (iss_vld != '0) |-> ($countones(iss_vld) <= int'($past(rob_free))));

    assert_iq_credit_R3: assert property (@(posedge clk) disable iff (rst)
        (iss_vld != '0) |-> ($countones(iss_vld) <= int'($past(iq_free))));

    assert_packed_slots_R2: assert property (@(posedge clk) disable iff (rst)
        (((iss_vld >> 1) & ~iss_vld) == '0));

    assert_stall_needs_activity_R3: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> (!walk_q && !sq_valid));

    assert_free_bound_R7: assert property (@(posedge clk) disable iff (rst)
        int'(fl_cnt) <= PHYS_REGS - 1);

    assert_log_bound_R8: assert property (@(posedge clk) disable iff (rst)
        int'(hcnt) <= HIST_DEPTH);

    for (genvar k = 0; k < REN_W; k++) begin : g_slot
        assert_dest_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
            (iss_vld[k] && iss_wr[k]) |-> (iss_pdst[k*PREG_W +: PREG_W] != '0));
        assert_nodest_zero_R6: assert property (@(posedge clk) disable iff (rst)
            (iss_vld[k] && !iss_wr[k]) |-> (iss_pdst[k*PREG_W +: PREG_W] == '0));
    end
endmodule

bind rnm_rename rnm_rename_chk u_chk (
    .clk(clk), .rst(rst), .dec_ready(dec_ready), .rob_free(rob_free), .iq_free(iq_free),
    .sq_valid(sq_valid), .iss_vld(iss_vld), .iss_pdst(iss_pdst), .iss_wr(iss_wr),
    .stall_o(stall_o), .walk_q(walk_q), .fl_cnt(fl_cnt), .hcnt(hcnt)
);

// File: tb/sim_rnm_rename.sv
module sim_rnm_rename;
    import rnm_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [REN_W-1:0]        dec_vld = '0;
    logic [REN_W*SEQ_W-1:0]  dec_seq = '0;
    logic [REN_W*AREG_W-1:0] dec_src1 = '0, dec_src2 = '0, dec_dst = '0;
    logic                    dec_ready;
    logic [CRED_W-1:0]       rob_free = '1, iq_free = '1;
    logic                    cm_valid = 1'b0, sq_valid = 1'b0;
    logic [SEQ_W-1:0]        cm_seq = '0, sq_seq = '0;
    logic [REN_W-1:0]        iss_vld, iss_wr;
    logic [REN_W*SEQ_W-1:0]  iss_seq;
    logic [REN_W*PREG_W-1:0] iss_psrc1, iss_psrc2, iss_pdst;
    logic                    stall_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rnm_rename u0 (
        .clk(clk), .rst(rst), .dec_vld(dec_vld), .dec_seq(dec_seq), .dec_src1(dec_src1),
        .dec_src2(dec_src2), .dec_dst(dec_dst), .dec_ready(dec_ready), .rob_free(rob_free),
        .iq_free(iq_free), .cm_valid(cm_valid), .cm_seq(cm_seq), .sq_valid(sq_valid),
        .sq_seq(sq_seq), .iss_vld(iss_vld), .iss_seq(iss_seq), .iss_psrc1(iss_psrc1),
        .iss_psrc2(iss_psrc2), .iss_pdst(iss_pdst), .iss_wr(iss_wr), .stall_o(stall_o)
    );

    // columns: seq, src1, src2, dst, exp psrc1, exp psrc2, exp pdst, exp wr
    localparam int VEC [0:7][0:7] = '{
        '{1, 1, 2, 3,  1,  2,  8, 1},
        '{2, 3, 0, 4,  8,  0,  9, 1},
        '{3, 3, 4, 3,  8,  9, 10, 1},
        '{4, 3, 5, 0, 10,  5,  0, 0},
        '{5, 7, 6, 5,  7,  6, 11, 1},
        '{6, 5, 5, 5, 11, 11, 12, 1},
        '{7, 0, 3, 6,  0, 10, 13, 1},
        '{8, 6, 4, 7, 13,  9, 14, 1}
    };

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int k, input int seq, input int s1, input int s2, input int d);
        dec_vld[k]                    = 1'b1;
        dec_seq[k*SEQ_W +: SEQ_W]     = SEQ_W'(seq);
        dec_src1[k*AREG_W +: AREG_W]  = AREG_W'(s1);
        dec_src2[k*AREG_W +: AREG_W]  = AREG_W'(s2);
        dec_dst[k*AREG_W +: AREG_W]   = AREG_W'(d);
    endtask

    task automatic slot(input string req, input int k, input int seq, input int p1,
                        input int p2, input int pd, input int wr);
        chk(req, "slot seq",   int'(iss_seq[k*SEQ_W +: SEQ_W]), seq);
        chk(req, "slot psrc1", int'(iss_psrc1[k*PREG_W +: PREG_W]), p1);
        chk(req, "slot psrc2", int'(iss_psrc2[k*PREG_W +: PREG_W]), p2);
        chk(req, "slot pdst",  int'(iss_pdst[k*PREG_W +: PREG_W]), pd);
        chk(req, "slot wr",    int'(iss_wr[k]), wr);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tick();
        // R10 reset state, R1 ready at rest
        chk("R10", "iss_vld after reset", int'(iss_vld), 0);
        chk("R1", "dec_ready after reset", int'(dec_ready), 1);
        chk("R10", "stall after reset", int'(stall_o), 0);

        // R2 R5 R6 R7: table of two-slot groups from reset state
        for (int g = 0; g < 4; g++) begin
            for (int j = 0; j < 2; j++)
                put(j, VEC[2*g+j][0], VEC[2*g+j][1], VEC[2*g+j][2], VEC[2*g+j][3]);
            tick();
            dec_vld = '0;
            tick();
            chk("R2", "group iss_vld", int'(iss_vld), 3);
            for (int j = 0; j < 2; j++)
                slot("R5", j, VEC[2*g+j][0], VEC[2*g+j][4], VEC[2*g+j][5],
                     VEC[2*g+j][6], VEC[2*g+j][7]);
        end

        // R3 free list runs dry mid-group, R8 commit refills it, R4 resume
        put(0, 9, 3, 4, 1);
        put(1, 10, 1, 0, 2);
        tick();
        dec_vld = '0;
        chk("R3", "stall with one free reg", int'(stall_o), 1);
        tick();
        chk("R4", "partial group iss_vld", int'(iss_vld), 1);
        slot("R3", 0, 9, 10, 9, 15, 1);
        chk("R3", "stall with empty free list", int'(stall_o), 1);
        cm_valid = 1'b1;
        cm_seq   = 8'd2;
        tick();
        cm_valid = 1'b0;
        chk("R8", "no rename before release", int'(iss_vld), 0);
        tick();
        chk("R4", "resumed slot iss_vld", int'(iss_vld), 1);
        slot("R8", 0, 10, 15, 0, 3, 1);

        // R9 squash: unwind to seq 6, drop the group offered with it
        sq_valid = 1'b1;
        sq_seq   = 8'd6;
        put(0, 11, 1, 7, 6);
        put(1, 12, 6, 2, 2);
        tick();
        sq_valid = 1'b0;
        dec_vld  = '0;
        chk("R9", "ready low in unwind", int'(dec_ready), 0);
        tick(); tick(); tick(); tick();
        chk("R9", "ready low at last unwind step", int'(dec_ready), 0);
        chk("R10", "quiet outputs during unwind", int'(iss_vld), 0);
        tick();
        chk("R9", "ready back after unwind", int'(dec_ready), 1);
        put(0, 11, 1, 7, 6);
        put(1, 12, 6, 2, 2);
        tick();
        dec_vld = '0;
        tick();
        chk("R1", "flushed group not renamed twice", int'(iss_vld), 3);
        slot("R9", 0, 11, 1, 7, 4, 1);
        slot("R7", 1, 12, 4, 2, 3, 1);

        // R3 reorder-buffer and issue-queue credits
        rob_free = 4'd1;
        put(0, 13, 2, 0, 1);
        put(1, 14, 1, 5, 7);
        tick();
        dec_vld = '0;
        chk("R3", "stall on one rob credit", int'(stall_o), 1);
        tick();
        chk("R3", "one rob credit iss_vld", int'(iss_vld), 1);
        slot("R3", 0, 13, 3, 0, 15, 1);
        rob_free = 4'd0;
        tick();
        chk("R3", "no rob credit iss_vld", int'(iss_vld), 0);
        chk("R3", "stall on no rob credit", int'(stall_o), 1);
        rob_free = '1;
        iq_free  = 4'd0;
        tick();
        chk("R3", "no iq credit iss_vld", int'(iss_vld), 0);
        iq_free = '1;
        tick();
        chk("R4", "resume after credits iss_vld", int'(iss_vld), 1);
        slot("R4", 0, 14, 15, 12, 14, 1);

        // R7 R10 fresh reset, R6 destination zero
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        chk("R10", "iss_vld after second reset", int'(iss_vld), 0);
        chk("R10", "stall after second reset", int'(stall_o), 0);
        put(0, 1, 3, 0, 3);
        put(1, 2, 0, 0, 0);
        tick();
        dec_vld = '0;
        tick();
        chk("R2", "post-reset group iss_vld", int'(iss_vld), 3);
        slot("R7", 0, 1, 3, 0, 8, 1);
        slot("R6", 1, 2, 0, 0, 0, 0);

        summary();
    end
endmodule